// File: doc/BRIEF.md
# Two-Level Display Interrupt Aggregator

This block collects display pipe events, such as vertical blank, into one interrupt line. Each pipe has a status register. It holds sticky event bits and a per-bit enable. The enabled bits of a pipe are ORed into a pipe line. The top level captures only the rising edge of each pipe line into an identity register, and a mask register can block that capture. The interrupt output is the OR of identity bits whose bit is set in an interrupt enable register.

Software reaches every register through a simple read and write port. Status and identity bits are cleared by writing ones. Because capture happens on edges and not on levels, an edge that arrives while its pipe is masked is lost for good. A pipe whose status stays set produces no further edges. Software must clear the pipe status, so that the pipe line falls, before that pipe can raise the interrupt again.

Top module: `disp_irq_agg`

## Requirements
- R1: After reset the status bits, status enables, identity register and interrupt enable register are zero, the mask register is all ones (every pipe blocked), and irq and rdata are 0.
- R2: A one-cycle pulse on bit i of ev_in (pipe p uses bits p*16+15 down to p*16) sets status bit i of pipe p at that clock edge. The bit stays set until software clears it, whether or not its enable is set.
- R3: The line of pipe p is the OR of its status bits whose enable bit is set. Reading address 2 returns pipe 0's line in bit 0 and pipe 1's line in bit 1, with zeros above.
- R4: One clock after the line of pipe p goes from 0 to 1, identity bit p is set, provided mask bit p is 0. Identity bits above bit 1 never set.
- R5: A rising edge that occurs while mask bit p is 1 never sets identity bit p. Clearing the mask bit later does not set it either, even while the line is still high.
- R6: While the line of pipe p stays high, further events on that pipe set no identity bit. After software clears the enabled status bits so that the line falls, the next event sets the identity bit again.
- R7: A write to address p (pipe 0 at 0, pipe 1 at 1) clears each status bit i of that pipe where wdata bit i is 1, leaves bits written 0 unchanged, and loads the enables from wdata[31:16]. A write to address 4 clears identity bits written with 1. Writes to address 3 and address 5 load the mask and the interrupt enable from wdata[7:0].
- R8: When a new event and a write-one-to-clear reach the same status bit in one cycle, the bit ends up set. The same holds for an identity bit whose edge capture meets a clear write.
- R9: irq is 1 exactly when some identity bit is 1 and the same bit of the interrupt enable register is 1.
- R10: When rd_en is high at a clock edge, rdata takes the value of the register at addr at that edge. Pipe p reads as {enables, status}, address 2 reads the live pipe lines, 3 the mask, 4 the identity, 5 the interrupt enable, and any other address reads 0. With rd_en low, rdata holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_in | input | 32 | Event pulses, 16 per pipe, pipe 0 in the low half |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after rd_en |
| irq | output | 1 | Interrupt output |

## Verification
Event capture and write-one-to-clear can hit the same bit in the same clock. The bench provokes this twice. First, it drives an event pulse and a clear write to the same status bit in one cycle. Second, it times a clear write to the identity register so that it lands in the cycle when the edge detector sets that bit, one clock after the event. In both cases a readback must show the bit still set.

// File: rtl/disp_irq_agg.sv
module disp_irq_agg #(
  parameter int NPIPE = 2,
  parameter int SW    = 16,
  parameter int IW    = 8,
  parameter int AW    = 3,
  parameter int DW    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPIPE*SW-1:0] ev_in,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [AW-1:0]       addr,
  input  logic [DW-1:0]       wdata,
  output logic [DW-1:0]       rdata,
  output logic                irq
);
  localparam int A_LIVE = NPIPE;
  localparam int A_MASK = NPIPE + 1;
  localparam int A_IDEN = NPIPE + 2;
  localparam int A_IER  = NPIPE + 3;

  logic [SW-1:0]    stat [NPIPE];
  logic [SW-1:0]    en   [NPIPE];
  logic [NPIPE-1:0] line, prev;
  logic [IW-1:0]    mask, iden, ier, rise;
  logic [DW-1:0]    rd_mux;

  wire w_mask = wr_en && addr == AW'(A_MASK);
  wire w_iden = wr_en && addr == AW'(A_IDEN);
  wire w_ier  = wr_en && addr == AW'(A_IER);

  always_ff @(posedge clk) begin
    for (int p = 0; p < NPIPE; p++) begin
      if (!rst_n) begin
        stat[p] <= '0;
        en[p]   <= '0;
      end else begin
        stat[p] <= ev_in[p*SW +: SW] |
                   (stat[p] & ~((wr_en && addr == AW'(p)) ? wdata[SW-1:0] : '0));
        if (wr_en && addr == AW'(p)) en[p] <= wdata[SW +: SW];
      end
    end
  end

  always_comb
    for (int p = 0; p < NPIPE; p++) line[p] = |(stat[p] & en[p]);

  assign rise = IW'(line & ~prev) & ~mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev <= '0;
      mask <= '1;
      iden <= '0;
      ier  <= '0;
    end else begin
      prev <= line;
      iden <= rise | (iden & ~(w_iden ? wdata[IW-1:0] : '0));
      if (w_mask) mask <= wdata[IW-1:0];
      if (w_ier)  ier  <= wdata[IW-1:0];
    end
  end

  assign irq = |(iden & ier);

  always_comb begin
    rd_mux = '0;
    for (int p = 0; p < NPIPE; p++)
      if (addr == AW'(p)) rd_mux = DW'({en[p], stat[p]});
    if (addr == AW'(A_LIVE)) rd_mux = DW'(line);
    if (addr == AW'(A_MASK)) rd_mux = DW'(mask);
    if (addr == AW'(A_IDEN)) rd_mux = DW'(iden);
    if (addr == AW'(A_IER))  rd_mux = DW'(ier);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (iden != '0));

  for (genvar g = 0; g < NPIPE; g++) begin : g_chk
    p_ev_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      |ev_in[g*SW +: SW] |=>
        ((stat[g] & $past(ev_in[g*SW +: SW])) == $past(ev_in[g*SW +: SW])));
    p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == AW'(g)) |=>
        ((stat[g] & $past(wdata[SW-1:0] & ~ev_in[g*SW +: SW])) == '0));
    p_edge_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(iden[g]) |-> $past(line[g] && !prev[g] && !mask[g]));
    p_masked_lost_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mask[g]) && !$past(iden[g])) |-> !iden[g]);
    p_no_retrig_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(line[g]) && $past(prev[g]) && !$past(iden[g])) |-> !iden[g]);
  end
endmodule

// File: tb/disp_irq_agg_test.sv
module disp_irq_agg_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] ev_in = '0;
  logic        wr_en = 0, rd_en = 0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          nchk = 0, nfail = 0;
  bit          done = 0;

  disp_irq_agg uut (.clk(clk), .rst_n(rst_n), .ev_in(ev_in), .wr_en(wr_en),
                    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #2 clk = ~clk;

  localparam logic [1:0] K_EV = 2'd0, K_WR = 2'd1, K_RD = 2'd2, K_IRQ = 2'd3;
  localparam int NV = 40;
  // {req, kind, addr, data, ev, expected}
  localparam logic [104:0] VEC [NV] = '{
    {4'd1,  K_RD,  3'd3, 32'h0,         32'h0,         32'hFF},        // R1 mask resets to all ones
    {4'd7,  K_WR,  3'd0, 32'h0002_0000, 32'h0,         32'h0},         // R7 enable pipe0 bit1
    {4'd7,  K_WR,  3'd3, 32'hFE,        32'h0,         32'h0},         // R7 unmask pipe0
    {4'd7,  K_WR,  3'd5, 32'h3,         32'h0,         32'h0},         // R7 irq enable
    {4'd2,  K_EV,  3'd0, 32'h0,         32'h0000_0002, 32'h0},         // R2
    {4'd2,  K_RD,  3'd0, 32'h0,         32'h0,         32'h0002_0002}, // R2
    {4'd3,  K_RD,  3'd2, 32'h0,         32'h0,         32'h1},         // R3
    {4'd4,  K_RD,  3'd4, 32'h0,         32'h0,         32'h1},         // R4
    {4'd9,  K_IRQ, 3'd0, 32'h0,         32'h0,         32'h1},         // R9
    {4'd7,  K_WR,  3'd4, 32'h1,         32'h0,         32'h0},         // R7 clear identity
    {4'd7,  K_RD,  3'd4, 32'h0,         32'h0,         32'h0},         // R7
    {4'd6,  K_EV,  3'd0, 32'h0,         32'h0000_0002, 32'h0},         // R6 line still high
    {4'd6,  K_RD,  3'd4, 32'h0,         32'h0,         32'h0},         // R6
    {4'd9,  K_IRQ, 3'd0, 32'h0,         32'h0,         32'h0},         // R9
    {4'd2,  K_EV,  3'd0, 32'h0,         32'h0000_0020, 32'h0},         // R2 disabled bit
    {4'd2,  K_RD,  3'd0, 32'h0,         32'h0,         32'h0002_0022}, // R2
    {4'd7,  K_WR,  3'd0, 32'h0002_0000, 32'h0,         32'h0},         // R7 zeros keep bits
    {4'd7,  K_RD,  3'd0, 32'h0,         32'h0,         32'h0002_0022}, // R7
    {4'd7,  K_WR,  3'd0, 32'h0002_0002, 32'h0,         32'h0},         // R7 clear bit1
    {4'd7,  K_RD,  3'd0, 32'h0,         32'h0,         32'h0002_0020}, // R7
    {4'd3,  K_RD,  3'd2, 32'h0,         32'h0,         32'h0},         // R3 line fell
    {4'd6,  K_EV,  3'd0, 32'h0,         32'h0000_0002, 32'h0},         // R6 re-armed
    {4'd6,  K_RD,  3'd4, 32'h0,         32'h0,         32'h1},         // R6
    {4'd5,  K_WR,  3'd1, 32'h0001_0000, 32'h0,         32'h0},         // R5 enable pipe1 bit0
    {4'd5,  K_EV,  3'd0, 32'h0,         32'h0001_0000, 32'h0},         // R5 masked edge
    {4'd3,  K_RD,  3'd2, 32'h0,         32'h0,         32'h3},         // R3
    {4'd5,  K_RD,  3'd4, 32'h0,         32'h0,         32'h1},         // R5
    {4'd5,  K_WR,  3'd3, 32'h0,         32'h0,         32'h0},         // R5 unmask all
    {4'd5,  K_RD,  3'd4, 32'h0,         32'h0,         32'h1},         // R5 edge stays lost
    {4'd9,  K_IRQ, 3'd0, 32'h0,         32'h0,         32'h1},         // R9
    {4'd6,  K_WR,  3'd1, 32'h0001_0001, 32'h0,         32'h0},         // R6 clear pipe1
    {4'd3,  K_RD,  3'd2, 32'h0,         32'h0,         32'h1},         // R3
    {4'd4,  K_EV,  3'd0, 32'h0,         32'h0001_0000, 32'h0},         // R4
    {4'd4,  K_RD,  3'd4, 32'h0,         32'h0,         32'h3},         // R4
    {4'd9,  K_WR,  3'd5, 32'h2,         32'h0,         32'h0},         // R9
    {4'd7,  K_WR,  3'd4, 32'h2,         32'h0,         32'h0},         // R7
    {4'd9,  K_IRQ, 3'd0, 32'h0,         32'h0,         32'h0},         // R9
    {4'd10, K_RD,  3'd5, 32'h0,         32'h0,         32'h2},         // R10
    {4'd10, K_RD,  3'd7, 32'h0,         32'h0,         32'h0},         // R10
    {4'd10, K_RD,  3'd1, 32'h0,         32'h0,         32'h0001_0001}  // R10
  };

  task automatic chk(input int r, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL R%0d: got %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic pulse(input logic [31:0] e);
    @(negedge clk); ev_in = e;
    @(negedge clk); ev_in = '0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    chk(1, {31'd0, irq}, 32'h0);   // R1
    chk(1, rdata, 32'h0);          // R1
    rst_n = 1;
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][100:99])
        K_EV:  pulse(VEC[i][63:32]);
        K_WR:  wr(VEC[i][98:96], VEC[i][95:64]);
        K_RD:  begin rd(VEC[i][98:96], d); chk(int'(VEC[i][104:101]), d, VEC[i][31:0]); end
        default: begin @(negedge clk); chk(int'(VEC[i][104:101]), {31'd0, irq}, VEC[i][31:0]); end
      endcase
    end

    // R8: event and clear reach the same status bit in one cycle
    @(negedge clk); ev_in = 32'h8; wr_en = 1; addr = 3'd0; wdata = 32'h0002_0008;
    @(negedge clk); ev_in = '0; wr_en = 0; wdata = '0;
    rd(3'd0, d); chk(8, d, 32'h0002_002A);

    // R8: identity capture meets identity clear
    wr(3'd0, 32'h0002_002A);
    wr(3'd4, 32'h3);
    rd(3'd4, d); chk(7, d, 32'h0);  // R7
    @(negedge clk); ev_in = 32'h2;
    @(negedge clk); ev_in = '0; wr_en = 1; addr = 3'd4; wdata = 32'h1;
    @(negedge clk); wr_en = 0; wdata = '0;
    rd(3'd4, d); chk(8, d, 32'h1);

    // R1: reset in mid-run
    wr(3'd5, 32'h3);
    @(negedge clk); chk(9, {31'd0, irq}, 32'h1);  // R9
    rd(3'd0, d);
    rst_n = 0;
    @(negedge clk);
    chk(1, {31'd0, irq}, 32'h0);
    chk(1, rdata, 32'h0);
    @(negedge clk); rst_n = 1;
    rd(3'd3, d); chk(1, d, 32'hFF);
    rd(3'd0, d); chk(1, d, 32'h0);
    rd(3'd4, d); chk(1, d, 32'h0);
    rd(3'd5, d); chk(1, d, 32'h0);
    rd(3'd2, d); chk(1, d, 32'h0);

    // R10: rdata holds while rd_en is low
    wr(3'd5, 32'h5);
    repeat (2) @(negedge clk);
    chk(10, rdata, 32'h0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule